// File: doc/BRIEF.md
# Square-Root Carry-Select Adder/Subtractor

A purely combinational 16-bit adder/subtractor. The operand bits are split into five blocks. From the least significant end their widths are 2, 2, 3, 4 and 5 bits. The lowest block is a plain ripple adder. Each higher block holds two ripple adders: one assumes a carry-in of 0 and the other a carry-in of 1. The carry leaving the block below drives a 2:1 multiplexer, which picks the correct sum bits and carry for the block. The slow path is therefore two full-adder delays plus one multiplexer per block boundary.

A single mode input chooses the operation. When it is low, the block returns `opnd_b + opnd_a`. When it is high, every bit of `opnd_a` is inverted by a 2:1 multiplexer, and the same mode bit feeds the carry into bit 0. The block then returns `opnd_b + ~opnd_a + 1`, which is `opnd_b - opnd_a` modulo 2^16. In that mode a carry-out of 1 means no borrow occurred.

Top module: `csa_addsub`

## Requirements
- R1: With `sub_mode`=0, `{carry_out, result}` equals the 17-bit sum `opnd_b + opnd_a`.
- R2: With `sub_mode`=1, `result` equals `(opnd_b - opnd_a) mod 65536`.
- R3: With `sub_mode`=1, `carry_out` is 1 exactly when `opnd_b >= opnd_a` as unsigned values, and 0 when a borrow occurs.
- R4: Carries propagate correctly across every block boundary. The boundaries lie between bits 1/2, 3/4, 6/7 and 10/11, and carry chains that start at bit 0 and end at any bit up to bit 15 or at `carry_out` produce the arithmetic result.
- R5: In each upper block, the carry-in-1 speculative result equals the carry-in-0 speculative result plus one, and carry-in-0 producing a carry implies carry-in-1 produces one.
- R6: The operand fed to the adders equals `opnd_a` when `sub_mode`=0 and its bitwise complement when `sub_mode`=1. At the ports: `opnd_a`=0 with `sub_mode`=1 gives `result`=`opnd_b` and `carry_out`=1.
- R7: Outputs depend only on the present inputs. A change on any input appears at the outputs without any clock edge.
- R8: Subtracting equal operands (`opnd_a`=`opnd_b`, `sub_mode`=1) yields `result`=0 and `carry_out`=1.
- R9: Adding all-ones to 1 (`opnd_a`=16'hFFFF, `opnd_b`=1, `sub_mode`=0) yields `result`=0 and `carry_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | Operand added to, or subtracted from, `opnd_b` |
| opnd_b | input | 16 | Base operand |
| sub_mode | input | 1 | 0 selects addition, 1 selects `opnd_b - opnd_a` |
| result | output | 16 | Sum or difference modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15; in subtract mode, 1 means no borrow |

## Verification
On every input change, the immediate assertions check four things:
- the operand-conditioning complement;
- the plus-one relation between each upper block's two speculative adders;
- the full 17-bit arithmetic identity at the top;
- the meaning of the borrow flag.

The assertions cannot show that the partition really carries across each of the four boundaries, or that the named corner values (equal operands, zero subtrahend, all-ones plus one) give their specific results. Only the bench's boundary-aimed carry chains, low-bit sweeps and random vectors demonstrate those.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int WIDTH   = 16;
  localparam int NUM_BLK = 5;

  // Block widths from least significant upward (2,2,3,4,5)
  function automatic int blk_width(input int idx);
    case (idx)
      0:       return 2;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int blk_lsb(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += blk_width(k);
    return acc;
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_maj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/csa_full_adder.sv
module csa_full_adder
  import csa_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = fa_sum(x, y, ci);
  assign co = fa_maj(x, y, ci);
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa_full_adder u_fa (
      .x  (a[i]),
      .y  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/csa_operand_cond.sv
module csa_operand_cond #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         inv,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_mux
    assign q[i] = inv ? ~a[i] : a[i];
  end

  // R6: each conditioned bit differs from the raw bit exactly when inverting
  always_comb begin
    a_r6_cond_complement: assert ((q ^ a) == {W{inv}})
      else $error("R6 operand conditioning mismatch");
  end
endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] spec_sum0, spec_sum1;
  logic         spec_cy0, spec_cy1;

  csa_ripple #(.W(W)) u_spec0 (
    .a(a), .b(b), .cin(1'b0), .sum(spec_sum0), .cout(spec_cy0)
  );
  csa_ripple #(.W(W)) u_spec1 (
    .a(a), .b(b), .cin(1'b1), .sum(spec_sum1), .cout(spec_cy1)
  );

  assign sum  = sel ? spec_sum1 : spec_sum0;
  assign cout = sel ? spec_cy1  : spec_cy0;

  // R5: the two speculative adders differ by exactly one
  always_comb begin
    a_r5_spec_plus_one: assert ({spec_cy1, spec_sum1} == ({spec_cy0, spec_sum0} + (W+1)'(1)))
      else $error("R5 speculative pair not one apart");
    a_r5_carry_monotone: assert (!spec_cy0 || spec_cy1)
      else $error("R5 carry with cin=0 but not with cin=1");
  end
endmodule

// File: rtl/csa_addsub.sv
module csa_addsub
  import csa_pkg::*;
(
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic        sub_mode,
  output logic [15:0] result,
  output logic        carry_out
);
  logic [WIDTH-1:0]   a_cond;
  logic [WIDTH-1:0]   sum_w;
  logic [NUM_BLK:0]   blk_cy;

  csa_operand_cond #(.W(WIDTH)) u_cond (
    .a(opnd_a), .inv(sub_mode), .q(a_cond)
  );

  // Mode bit doubles as the carry into bit 0
  assign blk_cy[0] = sub_mode;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    localparam int BW = blk_width(g);
    localparam int BL = blk_lsb(g);
    if (g == 0) begin : g_plain
      csa_ripple #(.W(BW)) u_rip (
        .a    (a_cond[BL +: BW]),
        .b    (opnd_b[BL +: BW]),
        .cin  (blk_cy[g]),
        .sum  (sum_w[BL +: BW]),
        .cout (blk_cy[g+1])
      );
    end else begin : g_sel
      csa_select_block #(.W(BW)) u_sel (
        .a    (a_cond[BL +: BW]),
        .b    (opnd_b[BL +: BW]),
        .sel  (blk_cy[g]),
        .sum  (sum_w[BL +: BW]),
        .cout (blk_cy[g+1])
      );
    end
  end

  assign result    = sum_w;
  assign carry_out = blk_cy[NUM_BLK];

  // R1/R2/R4: end-to-end arithmetic identity; R3: borrow meaning
  always_comb begin
    a_r1_identity: assert ({carry_out, result} ==
                           (17'(opnd_b) + 17'(a_cond) + 17'(sub_mode)))
      else $error("R1 sum identity broken");
    a_r3_borrow: assert (!sub_mode || (carry_out == (opnd_b >= opnd_a)))
      else $error("R3 borrow flag wrong");
  end
endmodule

// File: tb/test_csa_addsub.sv
module test_csa_addsub;
  logic        clk = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        sub_mode = 1'b0;
  logic [15:0] result;
  logic        carry_out;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  csa_addsub i_csa_addsub (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sub_mode(sub_mode),
    .result(result), .carry_out(carry_out)
  );

  task automatic run(input string tag, input logic [15:0] a, input logic [15:0] b, input logic m);
    logic [15:0] exp_r;
    logic        exp_c;
    @(posedge clk);
    #1;
    opnd_a = a; opnd_b = b; sub_mode = m;
    #2;
    if (!m) begin
      exp_r = 16'((int'(a) + int'(b)) % 65536);
      exp_c = (int'(a) + int'(b)) >= 65536;
    end else begin
      exp_r = 16'((int'(b) - int'(a) + 65536) % 65536);
      exp_c = int'(b) >= int'(a);
    end
    checks++;
    if (result !== exp_r || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s a=%h b=%h m=%0d actual=%0d/%h expected=%0d/%h",
               tag, a, b, m, carry_out, result, exp_c, exp_r);
    end
  endtask

  initial begin
    #100000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset-time state: zero inputs give zero sum
    run("R1 zero", 16'h0000, 16'h0000, 1'b0);
    run("R9 allones_plus_one", 16'hFFFF, 16'h0001, 1'b0);
    run("R1 max_plus_max", 16'hFFFF, 16'hFFFF, 1'b0);
    run("R6 sub_zero_subtrahend", 16'h0000, 16'h5A3C, 1'b1);
    run("R6 sub_zero_zero", 16'h0000, 16'h0000, 1'b1);
    run("R8 equal_operands", 16'hBEEF, 16'hBEEF, 1'b1);
    run("R8 equal_allones", 16'hFFFF, 16'hFFFF, 1'b1);
    run("R3 borrow_small", 16'h0001, 16'h0000, 1'b1);
    run("R3 borrow_big", 16'hFFFF, 16'h0000, 1'b1);
    run("R2 sub_plain", 16'h1234, 16'h8000, 1'b1);
    // R4: carry chains ending at every bit, incl. each block boundary
    for (int k = 1; k <= 16; k++) begin
      run("R4 chain_add", 16'((32'h1 << k) - 1), 16'h0001, 1'b0);
      run("R4 chain_sub", 16'h0001, 16'((32'h1 << k) & 32'hFFFF), 1'b1);
    end
    // R5: speculative selection exercised around each boundary (bits 2,4,7,11)
    for (int k = 0; k < 4; k++) begin
      int bnd;
      bnd = (k == 0) ? 2 : (k == 1) ? 4 : (k == 2) ? 7 : 11;
      run("R5 boundary_carry", 16'(32'h1 << (bnd - 1)), 16'(32'h1 << (bnd - 1)), 1'b0);
      run("R5 boundary_nocarry", 16'(32'h1 << (bnd - 1)), 16'h0000, 1'b0);
    end
    // R1/R2: sweep of low bits covering first two blocks fully
    for (int x = 0; x < 32; x++)
      for (int y = 0; y < 32; y++) begin
        run("R1 sweep_add", 16'(x), 16'(y), 1'b0);
        run("R2 sweep_sub", 16'(x), 16'(y), 1'b1);
      end
    // R7: inputs change with no clock dependency; random vectors
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      run("R7 random_add", ra, rb, 1'b0);
      run("R3 random_sub", ra, rb, 1'b1);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule